// File: doc/BRIEF.md
# Line Loss-of-Signal Detector

This block watches a recovered bipolar receive stream, one sample per receive interval, and raises or drops a loss-of-signal flag. Every interval it gets a positive and a negative mark strobe and two amplitude comparator results. One says the level is above the low threshold and the other says it is above the high threshold. The rules for raising the flag differ from the rules for dropping it. A quiet line raises it quickly. Dropping it needs evidence that a real signal has come back.

The block has two criteria, chosen by a configuration bit that software controls. The short-window criterion is the default. It raises the flag after a run of quiet intervals. It drops the flag only when the recent 32-interval history holds enough marks, has no long gap, and shows a strong amplitude. The long-window criterion is based on amplitude alone. It raises the flag after a long stretch of low level and drops it after a sustained strong level that carries marks. A clock-select output follows the flag: 1 selects the master reference clock and 0 selects the recovered clock. The mark strobes pass through to registered data outputs whatever the flag state.

Top module: `los_line_monitor`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `los_o` and `ref_clk_sel_o` are 1.
- R2: In short mode (`long_mode_i`=0) with `los_o`=0, `los_o` goes to 1 on the edge that samples the 32nd consecutive interval having no mark and `amp_low_ok_i`=0. Intervals with `amp_low_ok_i`=1 break the run.
- R3: A mark is `pos_mark_i` or `neg_mark_i` being 1. Either one alone ends a zero run.
- R4: In short mode with `los_o`=1, `los_o` goes to 0 on an edge only when three things hold for the 32 intervals ending with the current one: they hold at least 4 marks, they hold no run of 16 or more zeros, and the current `amp_high_ok_i`=1.
- R5: In long mode (`long_mode_i`=1) with `los_o`=0, `los_o` goes to 1 on the edge that samples the 2048th consecutive interval with `amp_low_ok_i`=0, whatever the marks do.
- R6: In long mode with `los_o`=1, `los_o` goes to 0 on the edge that samples the 33rd consecutive interval with `amp_high_ok_i`=1, provided that run contains at least one mark.
- R7: `ref_clk_sel_o` equals `los_o` on every cycle (1 = master reference clock).
- R8: `pos_data_o` and `neg_data_o` repeat `pos_mark_i` and `neg_mark_i` one clock later, whatever the LOS state.
- R9: On a clock where `long_mode_i` differs from the registered mode, `los_o` holds, that interval is discarded, and every run counter and the window restart as if the line had been silent.
- R10: In all other cases `los_o` keeps its value. Each decision takes effect on the same edge that samples the completing interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive interval clock |
| rst | input | 1 | Synchronous active-high reset |
| pos_mark_i | input | 1 | Positive mark strobe for this interval |
| neg_mark_i | input | 1 | Negative mark strobe for this interval |
| amp_low_ok_i | input | 1 | Level is above the low threshold |
| amp_high_ok_i | input | 1 | Level is above the high threshold |
| long_mode_i | input | 1 | 0 = short-window criterion, 1 = long-window criterion |
| los_o | output | 1 | Loss-of-signal flag |
| ref_clk_sel_o | output | 1 | Output clock select, 1 = master reference |
| pos_data_o | output | 1 | Registered positive data |
| neg_data_o | output | 1 | Registered negative data |

## Verification
The assertions assume that the comparator flags are already synchronous to `clk`, settle before each edge, and are sampled once per interval. They also assume the mode bit changes only at interval boundaries. The bench drives every input one time unit after a rising edge. It holds each value for a whole interval and keeps `amp_high_ok_i` from being 1 while `amp_low_ok_i` is 0, so no stimulus reports a strong but sub-threshold level. The randomized part changes mode only at regime boundaries and spaces those changes thousands of intervals apart, so both criteria can finish.

// File: rtl/los_pkg.sv
package los_pkg;
  typedef enum logic {
    MODE_SHORT = 1'b0,
    MODE_LONG  = 1'b1
  } los_mode_e;
endpackage

// File: rtl/los_run_counter.sv
// Saturating run counter: counts consecutive qualifying intervals.
// Exposes the next value so the parent can decide on the same edge.
module los_run_counter #(
  parameter int LIMIT = 33,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt_d
);
  logic [CW-1:0] cnt_q;

  always_comb begin
    if (clr || !inc)                 cnt_d = '0;
    else if (cnt_q == CW'(LIMIT))    cnt_d = cnt_q;
    else                             cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/los_mark_window.sv
// History of the last WIN intervals with a running count of marks.
module los_mark_window #(
  parameter int WIN = 32,
  localparam int OW = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          mark,
  output logic [OW-1:0] ones_d
);
  logic [WIN-1:0] hist_q, hist_d;
  logic [OW-1:0]  ones_q;

  always_comb begin
    if (clr) begin
      hist_d = '0;
      ones_d = '0;
    end else begin
      hist_d = {hist_q[WIN-2:0], mark};
      ones_d = ones_q + OW'(mark) - OW'(hist_q[WIN-1]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      ones_q <= '0;
    end else begin
      hist_q <= hist_d;
      ones_q <= ones_d;
    end
  end
endmodule

// File: rtl/los_gap_tracker.sv
// Decides whether the last WIN intervals contain a zero run longer than
// MAX_GAP. It keeps the trailing zero run and the age of the newest interval
// at which that run reached MAX_GAP+1. A long run lies fully inside the
// window exactly when that age is at most WIN-(MAX_GAP+1).
module los_gap_tracker #(
  parameter int WIN     = 32,
  parameter int MAX_GAP = 15,
  localparam int RUNL = MAX_GAP + 1,
  localparam int AGEL = WIN - RUNL + 1,
  localparam int ZW   = $clog2(RUNL + 1),
  localparam int AW   = $clog2(AGEL + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic mark,
  output logic gap_ok_d
);
  logic [ZW-1:0] zrun_q, zrun_d;
  logic [AW-1:0] age_q, age_d;
  logic          long_run;

  always_comb begin
    if (clr)                        zrun_d = ZW'(RUNL);
    else if (mark)                  zrun_d = '0;
    else if (zrun_q == ZW'(RUNL))   zrun_d = zrun_q;
    else                            zrun_d = zrun_q + ZW'(1);
    long_run = (zrun_d == ZW'(RUNL));
    if (clr || long_run)            age_d = '0;
    else if (age_q == AW'(AGEL))    age_d = age_q;
    else                            age_d = age_q + AW'(1);
    gap_ok_d = (age_d == AW'(AGEL));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zrun_q <= ZW'(RUNL);
      age_q  <= '0;
    end else begin
      zrun_q <= zrun_d;
      age_q  <= age_d;
    end
  end
endmodule

// File: rtl/los_line_monitor.sv
module los_line_monitor
  import los_pkg::*;
#(
  parameter int WIN       = 32,
  parameter int SHORT_SET = 32,
  parameter int MAX_GAP   = 15,
  parameter int MIN_MARKS = 4,
  parameter int LONG_SET  = 2048,
  parameter int LONG_CLR  = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic pos_mark_i,
  input  logic neg_mark_i,
  input  logic amp_low_ok_i,
  input  logic amp_high_ok_i,
  input  logic long_mode_i,
  output logic los_o,
  output logic ref_clk_sel_o,
  output logic pos_data_o,
  output logic neg_data_o
);
  localparam int QLIM = (LONG_SET > SHORT_SET) ? LONG_SET : SHORT_SET;
  localparam int QW   = $clog2(QLIM + 1);
  localparam int HLIM = LONG_CLR + 1;
  localparam int HW   = $clog2(HLIM + 1);
  localparam int OW   = $clog2(WIN + 1);

  los_mode_e     mode_q;
  logic          mode_long_q;
  logic          mode_chg;
  logic          mark;
  logic          quiet_inc;
  logic [QW-1:0] quiet_d;
  logic [HW-1:0] high_d;
  logic [OW-1:0] ones_d;
  logic          gap_ok_d;
  logic          hmark_q, hmark_d;
  logic          set_hit, clr_hit, los_d;

  assign mark        = pos_mark_i | neg_mark_i;
  assign mode_long_q = (mode_q == MODE_LONG);
  assign mode_chg    = (long_mode_i != mode_long_q);
  assign quiet_inc   = mode_long_q ? !amp_low_ok_i : (!mark && !amp_low_ok_i);

  los_run_counter #(.LIMIT(QLIM)) i_quiet_cnt (
    .clk(clk), .rst(rst), .clr(mode_chg), .inc(quiet_inc), .cnt_d(quiet_d)
  );

  los_run_counter #(.LIMIT(HLIM)) i_high_cnt (
    .clk(clk), .rst(rst), .clr(mode_chg), .inc(amp_high_ok_i), .cnt_d(high_d)
  );

  los_mark_window #(.WIN(WIN)) i_window (
    .clk(clk), .rst(rst), .clr(mode_chg), .mark(mark), .ones_d(ones_d)
  );

  los_gap_tracker #(.WIN(WIN), .MAX_GAP(MAX_GAP)) i_gap (
    .clk(clk), .rst(rst), .clr(mode_chg), .mark(mark), .gap_ok_d(gap_ok_d)
  );

  always_comb begin
    hmark_d = (mode_chg || !amp_high_ok_i) ? 1'b0 : (hmark_q | mark);
    if (mode_long_q) begin
      set_hit = (quiet_d >= QW'(LONG_SET));
      clr_hit = (high_d >= HW'(HLIM)) && hmark_d;
    end else begin
      set_hit = (quiet_d >= QW'(SHORT_SET));
      clr_hit = (ones_d >= OW'(MIN_MARKS)) && gap_ok_d && amp_high_ok_i;
    end
    if (mode_chg)   los_d = los_o;
    else if (los_o) los_d = !clr_hit;
    else            los_d = set_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q        <= MODE_SHORT;
      hmark_q       <= 1'b0;
      los_o         <= 1'b1;
      ref_clk_sel_o <= 1'b1;
      pos_data_o    <= 1'b0;
      neg_data_o    <= 1'b0;
    end else begin
      mode_q        <= long_mode_i ? MODE_LONG : MODE_SHORT;
      hmark_q       <= hmark_d;
      los_o         <= los_d;
      ref_clk_sel_o <= los_d;
      pos_data_o    <= pos_mark_i;
      neg_data_o    <= neg_mark_i;
    end
  end
endmodule

// File: rtl/los_line_monitor_chk.sv
module los_line_monitor_chk (
  input logic clk,
  input logic rst,
  input logic pos_mark_i,
  input logic neg_mark_i,
  input logic amp_low_ok_i,
  input logic amp_high_ok_i,
  input logic long_mode_i,
  input logic mode_long_q,
  input logic los_o,
  input logic ref_clk_sel_o,
  input logic pos_data_o,
  input logic neg_data_o
);
  // R1
  reset_flag_chk: assert property (@(posedge clk) rst |=> (los_o && ref_clk_sel_o));

  // R7
  sel_follows_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ref_clk_sel_o == los_o);

  // R8
  data_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pos_data_o == $past(pos_mark_i)) && (neg_data_o == $past(neg_mark_i)));

  // R2
  rise_needs_low_amp_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(los_o) |-> !$past(amp_low_ok_i));

  // R3
  short_rise_no_mark_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(los_o) && !$past(mode_long_q)) |-> !($past(pos_mark_i) || $past(neg_mark_i)));

  // R4
  fall_needs_high_amp_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(los_o) |-> $past(amp_high_ok_i));

  // R9
  mode_switch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (long_mode_i != mode_long_q) |=> $stable(los_o));
endmodule

bind los_line_monitor los_line_monitor_chk i_los_chk (
  .clk(clk), .rst(rst), .pos_mark_i(pos_mark_i), .neg_mark_i(neg_mark_i),
  .amp_low_ok_i(amp_low_ok_i), .amp_high_ok_i(amp_high_ok_i),
  .long_mode_i(long_mode_i), .mode_long_q(mode_long_q), .los_o(los_o),
  .ref_clk_sel_o(ref_clk_sel_o), .pos_data_o(pos_data_o), .neg_data_o(neg_data_o)
);

// File: tb/test_los_line_monitor.sv
module test_los_line_monitor;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pos = 1'b0, neg = 1'b0, lo = 1'b0, hi = 1'b0, md = 1'b0;
  logic los_o, sel_o, pos_o, neg_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  bit m_hist [32];
  int m_quiet, m_hrun;
  bit m_hmark, m_los, m_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  los_line_monitor i_los_line_monitor (
    .clk(clk), .rst(rst), .pos_mark_i(pos), .neg_mark_i(neg),
    .amp_low_ok_i(lo), .amp_high_ok_i(hi), .long_mode_i(md),
    .los_o(los_o), .ref_clk_sel_o(sel_o), .pos_data_o(pos_o), .neg_data_o(neg_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < 32; k++) m_hist[k] = 0;
    m_quiet = 0; m_hrun = 0; m_hmark = 0;
  endtask

  // Reference model written from the requirements, scanning the history directly.
  task automatic model_step(input bit p, input bit n, input bit l, input bit h, input bit d);
    bit m;
    int ones, run, maxrun;
    m = p | n;
    if (d != m_mode) begin  // R9
      m_mode = d;
      model_clear();
      return;
    end
    for (int k = 31; k > 0; k--) m_hist[k] = m_hist[k-1];
    m_hist[0] = m;
    ones = 0; run = 0; maxrun = 0;
    for (int k = 0; k < 32; k++) begin
      if (m_hist[k]) begin ones++; run = 0; end
      else begin run++; if (run > maxrun) maxrun = run; end
    end
    if (m_mode ? !l : (!m && !l)) m_quiet = (m_quiet < 2048) ? m_quiet + 1 : 2048;
    else m_quiet = 0;
    if (h) begin m_hrun = (m_hrun < 33) ? m_hrun + 1 : 33; m_hmark = m_hmark | m; end
    else begin m_hrun = 0; m_hmark = 0; end
    if (m_los) begin
      if (m_mode ? (m_hrun >= 33 && m_hmark) : (ones >= 4 && maxrun <= 15 && h)) m_los = 0;
    end else begin
      if (m_quiet >= (m_mode ? 2048 : 32)) m_los = 1;
    end
  endtask

  task automatic step(input bit p, input bit n, input bit l, input bit h, input bit d);
    pos = p; neg = n; lo = l; hi = h; md = d;
    model_step(p, n, l, h, d);
    @(posedge clk); #1;
    chk("R10 los vs model", los_o, m_los);
    chk("R7 clock select", sel_o, m_los);
    chk("R8 pos data", pos_o, p);
    chk("R8 neg data", neg_o, n);
  endtask

  task automatic do_reset();
    rst = 1; pos = 0; neg = 0; lo = 0; hi = 0; md = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 los in reset", los_o, 1'b1);
    chk("R1 select in reset", sel_o, 1'b1);
    rst = 0;
    model_clear(); m_los = 1; m_mode = 0;
  endtask

  int unsigned lfsr = 32'h1234_abcd;
  function automatic int unsigned rnd();
    lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
    return lfsr;
  endfunction

  initial begin
    do_reset();
    // R4: marks present but amplitude weak keeps LOS
    for (int i = 0; i < 40; i++) step(i % 8 == 0, i % 8 == 4, 1, 0, 0);
    chk("R4 weak amplitude holds", los_o, 1'b1);
    for (int i = 0; i < 40; i++) step(i % 8 == 0, i % 8 == 4, 1, 1, 0);
    chk("R4 short clear", los_o, 1'b0);
    // R2: zeros with level above low threshold never set
    for (int i = 0; i < 40; i++) step(0, 0, 1, 0, 0);
    chk("R2 low amplitude ok no set", los_o, 1'b0);
    for (int i = 0; i < 31; i++) step(0, 0, 0, 0, 0);
    chk("R2 31 quiet intervals", los_o, 1'b0);
    step(0, 0, 0, 0, 0);
    chk("R2 32nd quiet interval", los_o, 1'b1);
    // R3: a lone negative mark restarts the run
    for (int i = 0; i < 40; i++) step(i % 4 == 0, 0, 1, 1, 0);
    chk("R4 clear again", los_o, 1'b0);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    for (int i = 0; i < 31; i++) step(0, 0, 0, 0, 0);
    chk("R3 neg mark restarts run", los_o, 1'b0);
    step(0, 0, 0, 0, 0);
    chk("R3 set after restart", los_o, 1'b1);
    // R4: a 16-zero gap inside the window blocks clearing
    for (int i = 0; i < 16; i++) step(0, 0, 1, 1, 0);
    step(1, 0, 1, 1, 0); step(0, 1, 1, 1, 0); step(1, 0, 1, 1, 0); step(0, 1, 1, 1, 0);
    chk("R4 16-zero gap blocks", los_o, 1'b1);
    for (int i = 0; i < 20; i++) step(i % 2 == 0, 0, 1, 1, 0);
    chk("R4 clears once gap ages out", los_o, 1'b0);
    for (int i = 0; i < 32; i++) step(0, 0, 0, 0, 0);
    chk("R2 set before long mode", los_o, 1'b1);
    // R9 and R6: switch to long mode and clear with strong marked signal
    step(1, 0, 1, 1, 1);
    chk("R9 switch holds los", los_o, 1'b1);
    for (int i = 0; i < 32; i++) step(i % 3 == 0, 0, 1, 1, 1);
    chk("R6 32 strong intervals not enough", los_o, 1'b1);
    step(0, 0, 1, 1, 1);
    chk("R6 33rd strong interval clears", los_o, 1'b0);
    // R5: marks do not matter, only level
    for (int i = 0; i < 2047; i++) step(i % 2 == 0, i % 2 == 1, 0, 0, 1);
    chk("R5 2047 low intervals", los_o, 1'b0);
    step(1, 0, 0, 0, 1);
    chk("R5 2048th low interval", los_o, 1'b1);
    // R6: strong level without marks keeps LOS
    for (int i = 0; i < 50; i++) step(0, 0, 1, 1, 1);
    chk("R6 no mark no clear", los_o, 1'b1);
    step(1, 0, 1, 1, 1);
    for (int i = 0; i < 33; i++) step(0, 0, 1, 1, 1);
    chk("R6 clear with mark", los_o, 1'b0);
    // R9: partial long count is dropped on switch
    for (int i = 0; i < 2000; i++) step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    chk("R9 switch to short holds", los_o, 1'b0);
    for (int i = 0; i < 31; i++) step(0, 0, 0, 0, 0);
    chk("R9 counters restarted", los_o, 1'b0);
    step(0, 0, 0, 0, 0);
    chk("R2 set after switch", los_o, 1'b1);
    // R10: randomized regimes compared against the model every interval
    for (int i = 0; i < 22000; i++) begin
      int reg_sel, dens;
      int unsigned r;
      bit p, n, l, h, d;
      reg_sel = (i / 2200) % 4;
      d = ((i / 8800) % 2) == 1;
      dens = (reg_sel == 0) ? 2 : (reg_sel == 1) ? 6 : (reg_sel == 2) ? 14 : 40;
      r = rnd();
      p = (r % dens) == 0;
      n = !p && ((r >> 8) % dens) == 0;
      h = (reg_sel != 3) && ((r >> 16) % 8) != 0;
      l = (reg_sel != 3) && (h || ((r >> 20) % 2) == 0);
      step(p, n, l, h, d);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule